// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Tape Tone Mode

This block shifts one byte out on a single serial line. Each frame is 11 bits long: a start bit, eight data bits and two stop bits. The bit period comes from one of two sources. The first is a prescaler that divides the basic clock by a power of two chosen with a 3-bit code. The second is an external bit clock, which is synchronized and edge-detected.

In NRZ mode the line carries the bit levels directly. In tape mode the same frame is sent as frequency-shift keying. A 0 bit plays tone FX for one bit period, and a 1 bit plays tone FY. Each tone has its own divider code.

Bytes arrive on a valid/ready stream port. `tx_ready` is high only while no frame is in progress, and a byte is taken on a clock edge where `tx_valid` and `tx_ready` are both high. The block does not store a byte offered while `tx_ready` is low. A source that wants the byte sent must hold `tx_valid` and `tx_data` until it is accepted. The configuration inputs must stay stable while `busy` is high.

Top module: `sio_tape_tx`

## Requirements
- R1: In NRZ mode (`tape_mode`=0) a frame drives 0 (start), then `tx_data` bit 0 up to bit 7, then 1 and 1 (stops). The line is 1 when no frame is in progress.
- R2: With `ext_sel`=0 every bit lasts exactly P basic-clock cycles. P is set by `rate_sel` as follows: 0→1, 1→2, 2→128, 3→256, 4→512, 5→1024, 6→2048, 7→4096.
- R3: `busy` goes high on the cycle after a byte is accepted and stays high for 11 bit periods. `tx_ready` equals the inverse of `busy`.
- R4: A `tx_valid` pulse while `busy` is high changes nothing: the current frame continues unchanged and no extra frame follows it.
- R5: `done` is set when `busy` falls after the second stop bit. It is cleared by the next accepted byte.
- R6: With `ext_sel`=1 each rising edge of `ext_bit_clk` moves the frame on by one bit, about three clock cycles after the edge. The internal prescaler has no effect in this mode.
- R7: In tape mode a 0 bit outputs tone FX and a 1 bit outputs tone FY. The idle line outputs FY. Tone period codes (`fx_sel`/`fy_sel`) are 0→64, 1→128, 2→256, 3→512, 4→1024 basic clocks; codes 5 to 7 also give 1024.
- R8: Both tones restart their phase when a byte is accepted. When the bit period is a multiple of the tone period, every bit therefore starts with the line low and contains whole tone cycles.
- R9: After reset `sdo`=1, `busy`=0, `done`=0 and `tx_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Basic clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_sel | input | 1 | 1: bit clock from `ext_bit_clk`; 0: from the prescaler |
| rate_sel | input | 3 | Prescaler ratio code |
| tape_mode | input | 1 | 1: FSK tone output; 0: NRZ |
| fx_sel | input | 3 | Tone code for 0 bits |
| fy_sel | input | 3 | Tone code for 1 bits and idle |
| ext_bit_clk | input | 1 | Asynchronous external bit clock |
| tx_valid | input | 1 | Byte offered |
| tx_data | input | 8 | Byte to send |
| tx_ready | output | 1 | Byte can be accepted |
| busy | output | 1 | Frame in progress |
| done | output | 1 | Last frame completed |
| sdo | output | 1 | Serial output line |

## Verification
The bench keeps the default parameters: a prescaler gap of 5, which makes code 2 give 128, and a tone base shift of 6, which makes the shortest tone 64. With these values the largest ratio of 4096 fits in one frame of about 45,000 cycles, so every prescaler code can be run as a full frame. The 128-cycle bit period is also an exact multiple of the 64- and 128-cycle tones, so counting rising edges in each bit window identifies the tone independently of its phase. The idle tone at code 6 is checked over a 2048-cycle window, which confirms that out-of-range codes are clamped to the largest ratio.

// File: rtl/sio_tx_pkg.sv
package sio_tx_pkg;
  localparam int FRAME_BITS = 11;
  localparam int IDX_W      = 4;

  // prescaler code to shift amount: codes 0/1 are direct, the rest skip a gap
  function automatic int rate_shift(input logic [2:0] sel, input int gap);
    return (sel < 3'd2) ? int'(sel) : int'(sel) + gap;
  endfunction

  // tone code to shift amount, codes above 4 clamp to the longest tone
  function automatic int tone_shift(input logic [2:0] sel, input int base);
    return (sel > 3'd4) ? base + 4 : base + int'(sel);
  endfunction
endpackage

// File: rtl/sio_bit_timer.sv
module sio_bit_timer
  import sio_tx_pkg::*;
#(
  parameter int RATE_GAP = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       restart,
  input  logic       ext_sel,
  input  logic [2:0] rate_sel,
  input  logic       ext_clk,
  output logic       tick
);
  localparam int CNT_W = 7 + RATE_GAP;

  logic [2:0]       sync_q;
  logic [CNT_W-1:0] div_cnt;
  logic [CNT_W-1:0] div_mask;
  logic             ext_rise;
  logic             int_term;

  always_ff @(posedge clk) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[1:0], ext_clk};
  end

  always_comb begin
    ext_rise = sync_q[1] & ~sync_q[2];
    div_mask = ~({CNT_W{1'b1}} << rate_shift(rate_sel, RATE_GAP));
    int_term = (div_cnt == div_mask);
    tick     = run & (ext_sel ? ext_rise : int_term);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || restart)      div_cnt <= '0;
    else if (run && !ext_sel)   div_cnt <= int_term ? '0 : div_cnt + 1'b1;
  end

  AST_DIV_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !ext_sel) |-> (div_cnt <= div_mask)); // R2
endmodule

// File: rtl/sio_tone_gen.sv
module sio_tone_gen
  import sio_tx_pkg::*;
#(
  parameter int TONE_BASE = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       restart,
  input  logic [2:0] fx_sel,
  input  logic [2:0] fy_sel,
  output logic       fx_wave,
  output logic       fy_wave
);
  localparam int TCNT_W = TONE_BASE + 4;

  logic [TCNT_W-1:0] phase;

  always_ff @(posedge clk) begin
    if (!rst_n || restart) phase <= '0;
    else                   phase <= phase + 1'b1;
  end

  always_comb begin
    fx_wave = phase[tone_shift(fx_sel, TONE_BASE) - 1];
    fy_wave = phase[tone_shift(fy_sel, TONE_BASE) - 1];
  end

  AST_TONE_RESTART_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $past(restart) |-> (!fx_wave && !fy_wave)); // R8
endmodule

// File: rtl/sio_frame_shifter.sv
module sio_frame_shifter
  import sio_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       accept,
  input  logic [7:0] data,
  input  logic       tick,
  output logic       busy,
  output logic       done,
  output logic       line_bit
);
  logic [FRAME_BITS-1:0] shreg;
  logic [IDX_W-1:0]      idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg <= '1;
      idx   <= '0;
      busy  <= 1'b0;
      done  <= 1'b0;
    end else if (accept) begin
      shreg <= {2'b11, data, 1'b0};
      idx   <= '0;
      busy  <= 1'b1;
      done  <= 1'b0;
    end else if (busy && tick) begin
      shreg <= {1'b1, shreg[FRAME_BITS-1:1]};
      if (idx == IDX_W'(FRAME_BITS - 1)) begin
        busy <= 1'b0;
        done <= 1'b1;
      end else begin
        idx <= idx + 1'b1;
      end
    end
  end

  assign line_bit = shreg[0];

  AST_DONE_ON_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done); // R5
  AST_DONE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !done); // R5
  AST_FULL_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(idx) == IDX_W'(FRAME_BITS - 1))); // R3
  AST_HOLD_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$past(tick) && !$past(accept)) |-> $stable(shreg)); // R4
endmodule

// File: rtl/sio_tape_tx.sv
module sio_tape_tx
  import sio_tx_pkg::*;
#(
  parameter int RATE_GAP  = 5,
  parameter int TONE_BASE = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ext_sel,
  input  logic [2:0] rate_sel,
  input  logic       tape_mode,
  input  logic [2:0] fx_sel,
  input  logic [2:0] fy_sel,
  input  logic       ext_bit_clk,
  input  logic       tx_valid,
  input  logic [7:0] tx_data,
  output logic       tx_ready,
  output logic       busy,
  output logic       done,
  output logic       sdo
);
  logic accept;
  logic tick;
  logic line_bit;
  logic fx_wave;
  logic fy_wave;

  assign tx_ready = ~busy;
  assign accept   = tx_valid & ~busy;

  sio_bit_timer #(.RATE_GAP(RATE_GAP)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (busy),
    .restart  (accept),
    .ext_sel  (ext_sel),
    .rate_sel (rate_sel),
    .ext_clk  (ext_bit_clk),
    .tick     (tick)
  );

  sio_tone_gen #(.TONE_BASE(TONE_BASE)) u_tones (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (accept),
    .fx_sel  (fx_sel),
    .fy_sel  (fy_sel),
    .fx_wave (fx_wave),
    .fy_wave (fy_wave)
  );

  sio_frame_shifter u_frame (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (accept),
    .data     (tx_data),
    .tick     (tick),
    .busy     (busy),
    .done     (done),
    .line_bit (line_bit)
  );

  always_comb begin
    if (tape_mode) sdo = (busy && !line_bit) ? fx_wave : fy_wave;
    else           sdo = busy ? line_bit : 1'b1;
  end

  AST_START_BIT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy) && !tape_mode) |-> !sdo); // R1
  AST_STOP_BIT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && !tape_mode && !$past(tape_mode)) |-> $past(sdo)); // R1
endmodule

// File: tb/sio_tape_tx_bench.sv
`timescale 1ns/1ps
module sio_tape_tx_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ext_sel = 1'b0;
  logic [2:0] rate_sel = 3'd0;
  logic       tape_mode = 1'b0;
  logic [2:0] fx_sel = 3'd0;
  logic [2:0] fy_sel = 3'd1;
  logic       ext_bit_clk = 1'b0;
  logic       tx_valid = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic       tx_ready, busy, done, sdo;

  int n_cmp = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  sio_tape_tx u_sio_tape_tx (
    .clk(clk), .rst_n(rst_n), .ext_sel(ext_sel), .rate_sel(rate_sel),
    .tape_mode(tape_mode), .fx_sel(fx_sel), .fy_sel(fy_sel),
    .ext_bit_clk(ext_bit_clk), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_ready(tx_ready), .busy(busy), .done(done), .sdo(sdo)
  );

  // {rate code, byte}
  localparam logic [10:0] VEC [8] = '{
    {3'd0, 8'hA5}, {3'd1, 8'h3C}, {3'd0, 8'h00}, {3'd1, 8'hFF},
    {3'd2, 8'h81}, {3'd0, 8'h5A}, {3'd3, 8'h01}, {3'd1, 8'h80}
  };

  function automatic int bit_period(input logic [2:0] code);
    int p;
    case (code)
      3'd0: p = 1;    3'd1: p = 2;    3'd2: p = 128;  3'd3: p = 256;
      3'd4: p = 512;  3'd5: p = 1024; 3'd6: p = 2048; default: p = 4096;
    endcase
    return p;
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic offer(input logic [7:0] d);
    @(negedge clk);
    tx_data  = d;
    tx_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  // NRZ frame with optional poke of a second byte while busy
  task automatic send_nrz(input logic [2:0] rs, input logic [7:0] d, input int poke_j);
    int n;
    logic [10:0] fr;
    n  = bit_period(rs);
    fr = {2'b11, d, 1'b0};
    @(negedge clk);
    rate_sel = rs;
    offer(d);
    for (int j = 0; j <= 11 * n; j++) begin
      if (j > 0) @(negedge clk);
      if (j == 0) begin
        check("R3", "busy after accept", busy, 1);
        check("R3", "ready while busy", tx_ready, 0);
        check("R5", "done cleared by accept", done, 0);
      end
      if (j == poke_j) begin tx_valid = 1'b1; tx_data = ~d; end
      if (j == poke_j + 1) tx_valid = 1'b0;
      if (j < 11 * n && (j % n) == n / 2)
        check((j / n == 0) ? "R2" : "R1", $sformatf("bit %0d", j / n), sdo, fr[j / n]);
      if (j == 11 * n) begin
        check("R3", "busy after 11 periods", busy, 0);
        check("R5", "done after frame", done, 1);
        check("R1", "idle line", sdo, 1);
      end
    end
  endtask

  task automatic count_rises(input int samples, output int rises);
    logic prev;
    rises = 0;
    @(negedge clk);
    prev = sdo;
    for (int i = 1; i < samples; i++) begin
      @(negedge clk);
      if (sdo && !prev) rises++;
      prev = sdo;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL R3 watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int r;
    logic [10:0] fr;
    repeat (4) @(negedge clk);
    check("R9", "reset sdo", sdo, 1);
    check("R9", "reset busy", busy, 0);
    check("R9", "reset done", done, 0);
    check("R9", "reset ready", tx_ready, 1);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // table walk: NRZ frames at several rates (R1 R2 R3 R5)
    foreach (VEC[i]) send_nrz(VEC[i][10:8], VEC[i][7:0], -1);

    // R4: byte offered mid-frame is dropped
    send_nrz(3'd1, 8'h0F, 3);
    repeat (6) @(negedge clk);
    check("R4", "no second frame", busy, 0);
    check("R4", "line stays idle", sdo, 1);

    // R2: largest ratio
    send_nrz(3'd7, 8'h96, -1);

    // R6: external bit clock
    ext_sel = 1'b1;
    rate_sel = 3'd0;
    fr = {2'b11, 8'hB4, 1'b0};
    offer(8'hB4);
    repeat (20) @(negedge clk);
    check("R6", "start bit held without ext edge", sdo, 0);
    for (int k = 1; k <= 11; k++) begin
      ext_bit_clk = 1'b1;
      repeat (3) @(negedge clk);
      ext_bit_clk = 1'b0;
      repeat (3) @(negedge clk);
      if (k <= 10) check("R6", $sformatf("ext bit %0d", k), sdo, fr[k]);
    end
    check("R6", "ext frame done", done, 1);
    check("R6", "ext busy cleared", busy, 0);
    ext_sel = 1'b0;

    // R7 R8: tape mode
    tape_mode = 1'b1;
    fx_sel = 3'd0;
    fy_sel = 3'd1;
    count_rises(257, r);
    check("R7", "idle FY rises in 256", r, 2);
    rate_sel = 3'd2;
    fr = {2'b11, 8'hC5, 1'b0};
    offer(8'hC5);
    for (int k = 0; k < 11; k++) begin
      logic prev;
      int rc;
      rc = 0;
      if (k > 0) @(negedge clk);
      check("R8", $sformatf("tape bit %0d starts low", k), sdo, 0);
      prev = sdo;
      for (int j = 1; j < 128; j++) begin
        @(negedge clk);
        if (sdo && !prev) rc++;
        prev = sdo;
      end
      check("R7", $sformatf("tape bit %0d tone", k), rc, fr[k] ? 1 : 2);
    end
    @(negedge clk);
    check("R3", "tape frame ended", busy, 0);
    fy_sel = 3'd6;
    count_rises(2049, r);
    check("R7", "clamped FY code rises in 2048", r, 2);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule